// File: doc/BRIEF.md
# UART Automatic Flow Controller

This block sits between the FIFOs and the serial shifters of a UART whose FIFOs hold 128 entries. It keeps the far end from overrunning the local receive FIFO. It compares the receive fill level against a programmable upper mark and a programmable lower mark. The result is a single throttle state.

That throttle state acts in one of two ways, or both:

- **In-band:** it asks for a programmable stop character or go character to be sent ahead of the next queued data byte.
- **Out-of-band:** it drives one of two active-low handshake outputs, either the request-to-send line or the data-terminal-ready line.

In the other direction, the block recognises the stop and go characters arriving from the far end. It removes them from the receive stream and pauses or resumes data transmission to match. It also watches the selected active-low clear-to-send or data-set-ready input, and halts the transmitter entirely while that input is high.

Loads into the transmit shifter happen only when the shifter reports that it is idle. As a result, a character already being shifted is never cut short. The transmitter and the receiver can each be switched off. Four status outputs give the current flow state for a register file to read.

Top module: `uart_flow_ctrl`

## Requirements
- R1: The throttle state (`stat_throttled`) becomes 1 on the clock edge after `rx_level >= cfg_thr_hi`. It becomes 0 on the edge after `rx_level <= cfg_thr_lo` while the level is below the upper mark. Between the two marks it holds its value.
- R2: With `cfg_oob_en`=1 and `cfg_oob_pair`=0, `rts_n` equals the throttle state and `dtr_n` is 0. With `cfg_oob_pair`=1, `dtr_n` equals the throttle state and `rts_n` is 0. With `cfg_oob_en`=0, both outputs are 0.
- R3: With `cfg_inband_en`=1, a change of the throttle state from 0 to 1 requests one `cfg_stop_char`, and a change back to 0 requests one `cfg_go_char`. `stat_stop_sent` is 1 from the edge that loads a stop character until the edge that loads a go character.
- R4: A pending stop or go character is loaded in preference to a waiting FIFO byte. In that cycle `tx_fifo_pop` is 0.
- R5: `tx_load` is 1 only when both `tx_shift_idle` and `tx_enable` are 1.
- R6: With `cfg_inband_en`=1, a received character equal to `cfg_stop_char` or `cfg_go_char` does not produce `rx_fifo_wr`. A stop character sets `stat_remote_stop` on the next edge, which blocks FIFO data loads. A go character clears it. With `cfg_inband_en`=0, both characters are written like any other byte and `stat_remote_stop` is 0.
- R7: With `cfg_oob_en`=1, a high level on `cts_n` (pair 0) or `dsr_n` (pair 1) sets `stat_oob_hold` two clock edges later. While it is set, no character is loaded, including stop and go characters. Loading resumes two edges after the input returns low. The input of the unselected pair has no effect.
- R8: While `rx_enable`=0, received characters produce no `rx_fifo_wr` and do not change `stat_remote_stop`.
- R9: After reset, `rts_n`, `dtr_n`, `tx_load`, `tx_fifo_pop` and all four status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_inband_en | input | 1 | Enable stop/go character flow control |
| cfg_oob_en | input | 1 | Enable handshake-line flow control |
| cfg_oob_pair | input | 1 | 0: request-to-send / clear-to-send, 1: data-terminal-ready / data-set-ready |
| cfg_stop_char | input | 8 | Stop character value |
| cfg_go_char | input | 8 | Go character value |
| cfg_thr_hi | input | 8 | Upper fill mark (0..128) |
| cfg_thr_lo | input | 8 | Lower fill mark (0..128) |
| rx_level | input | 8 | Receive FIFO fill level |
| rx_enable | input | 1 | Receiver enable |
| rx_char_valid | input | 1 | A received character is presented |
| rx_char | input | 8 | Received character |
| rx_fifo_wr | output | 1 | Write the presented character into the receive FIFO |
| tx_enable | input | 1 | Transmitter enable |
| tx_fifo_valid | input | 1 | Transmit FIFO holds a byte |
| tx_fifo_data | input | 8 | Head byte of the transmit FIFO |
| tx_shift_idle | input | 1 | Transmit shifter can accept a character |
| tx_fifo_pop | output | 1 | Remove the head byte from the transmit FIFO |
| tx_load | output | 1 | Load `tx_load_data` into the shifter |
| tx_load_data | output | 8 | Character to shift out |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| stat_throttled | output | 1 | Local receive side is throttled |
| stat_stop_sent | output | 1 | Stop character sent, go character not yet sent |
| stat_remote_stop | output | 1 | Far end sent a stop character |
| stat_oob_hold | output | 1 | Selected handshake input is holding the transmitter |

## Verification
The assertions assume that the configuration inputs stay stable while the block runs. They also assume that the upper mark sits above the lower mark. The bench changes configuration only between scenarios and always programs the upper mark higher than the lower one. The assertions further assume that `rx_char_valid` appears with a settled `rx_char`. The bench drives every input on the falling edge, so both rules are met before each sampling edge.

// File: rtl/fc_pkg.sv
package fc_pkg;
   typedef enum logic {
      PAIR_RTS_CTS = 1'b0,
      PAIR_DTR_DSR = 1'b1
   } oob_pair_e;

   function automatic int lvl_width(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("fc_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d};
   end

   generate
      if (STAGES == 1) begin : g_one
         assign q = chain_q[0];
      end else begin : g_many
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/fc_level_watch.sv
module fc_level_watch #(
   parameter int LVL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] thr_hi,
   input  logic [LVL_W-1:0] thr_lo,
   output logic             throttle
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                throttle <= 1'b0;
      else if (level >= thr_hi)  throttle <= 1'b1;
      else if (level <= thr_lo)  throttle <= 1'b0;
   end

   // R1: reaching the upper mark throttles on the next edge
   p_rise_at_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (level >= thr_hi) |=> throttle);
   // R1: dropping to the lower mark releases on the next edge
   p_fall_at_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (level <= thr_lo && level < thr_hi) |=> !throttle);
   // R1: between the marks the state holds
   p_hold_between_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (level > thr_lo && level < thr_hi) |=> $stable(throttle));
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_req,
   input  logic [DATA_W-1:0] ctrl_char,
   input  logic              fifo_valid,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              shift_idle,
   input  logic              tx_enable,
   input  logic              data_hold,
   input  logic              all_hold,
   output logic              load,
   output logic [DATA_W-1:0] load_data,
   output logic              pop,
   output logic              ctrl_taken
);
   logic slot_free;

   always_comb begin
      slot_free  = shift_idle && tx_enable && !all_hold;
      ctrl_taken = slot_free && ctrl_req;
      pop        = slot_free && !ctrl_req && fifo_valid && !data_hold;
      load       = ctrl_taken || pop;
      load_data  = ctrl_req ? ctrl_char : fifo_data;
   end

   // R5: no load unless the shifter is idle and the transmitter is on
   p_load_needs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (shift_idle && tx_enable));
   // R4: a pending control character blocks the FIFO pop
   p_ctrl_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_req |-> !pop);
   // R7: handshake hold stops every load
   p_oob_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      all_hold |-> !load);
   // R6: far-end stop blocks data bytes
   p_remote_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      data_hold |-> !pop);
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
   import fc_pkg::*;
#(
   parameter int FIFO_DEPTH  = 128,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int LVL_W      = lvl_width(FIFO_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_inband_en,
   input  logic              cfg_oob_en,
   input  logic              cfg_oob_pair,
   input  logic [DATA_W-1:0] cfg_stop_char,
   input  logic [DATA_W-1:0] cfg_go_char,
   input  logic [LVL_W-1:0]  cfg_thr_hi,
   input  logic [LVL_W-1:0]  cfg_thr_lo,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic              rx_enable,
   input  logic              rx_char_valid,
   input  logic [DATA_W-1:0] rx_char,
   output logic              rx_fifo_wr,
   input  logic              tx_enable,
   input  logic              tx_fifo_valid,
   input  logic [DATA_W-1:0] tx_fifo_data,
   input  logic              tx_shift_idle,
   output logic              tx_fifo_pop,
   output logic              tx_load,
   output logic [DATA_W-1:0] tx_load_data,
   input  logic              cts_n,
   input  logic              dsr_n,
   output logic              rts_n,
   output logic              dtr_n,
   output logic              stat_throttled,
   output logic              stat_stop_sent,
   output logic              stat_remote_stop,
   output logic              stat_oob_hold
);
   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("uart_flow_ctrl: FIFO_DEPTH must be at least 2");
   end
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("uart_flow_ctrl: DATA_W must be 5..9");
   end

   // ---------------- receive level watch ----------------
   logic throttle;

   fc_level_watch #(.LVL_W(LVL_W)) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (rx_level),
      .thr_hi   (cfg_thr_hi),
      .thr_lo   (cfg_thr_lo),
      .throttle (throttle)
   );

   // ---------------- handshake outputs ----------------
   always_comb begin
      rts_n = cfg_oob_en && (oob_pair_e'(cfg_oob_pair) == PAIR_RTS_CTS) && throttle;
      dtr_n = cfg_oob_en && (oob_pair_e'(cfg_oob_pair) == PAIR_DTR_DSR) && throttle;
   end

   // ---------------- handshake inputs ----------------
   logic cts_s, dsr_s, oob_hold;

   fc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_cts_sync (
      .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_s));
   fc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_dsr_sync (
      .clk(clk), .rst_n(rst_n), .d(dsr_n), .q(dsr_s));

   assign oob_hold = cfg_oob_en &&
                     ((oob_pair_e'(cfg_oob_pair) == PAIR_DTR_DSR) ? dsr_s : cts_s);

   // ---------------- in-band character request ----------------
   logic              stop_sent_q;
   logic              ctrl_req;
   logic [DATA_W-1:0] ctrl_char;
   logic              ctrl_taken;

   always_comb begin
      ctrl_req  = cfg_inband_en && (throttle != stop_sent_q);
      ctrl_char = throttle ? cfg_stop_char : cfg_go_char;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stop_sent_q <= 1'b0;
      else if (ctrl_taken) stop_sent_q <= throttle;
   end

   // ---------------- received character filter ----------------
   logic rx_take, rx_is_stop, rx_is_go, remote_stop_q;

   always_comb begin
      rx_take    = rx_enable && rx_char_valid;
      rx_is_stop = cfg_inband_en && (rx_char == cfg_stop_char);
      rx_is_go   = cfg_inband_en && (rx_char == cfg_go_char);
      rx_fifo_wr = rx_take && !rx_is_stop && !rx_is_go;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     remote_stop_q <= 1'b0;
      else if (!cfg_inband_en)        remote_stop_q <= 1'b0;
      else if (rx_take && rx_is_stop) remote_stop_q <= 1'b1;
      else if (rx_take && rx_is_go)   remote_stop_q <= 1'b0;
   end

   // ---------------- transmit gate ----------------
   fc_tx_gate #(.DATA_W(DATA_W)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_req   (ctrl_req),
      .ctrl_char  (ctrl_char),
      .fifo_valid (tx_fifo_valid),
      .fifo_data  (tx_fifo_data),
      .shift_idle (tx_shift_idle),
      .tx_enable  (tx_enable),
      .data_hold  (remote_stop_q),
      .all_hold   (oob_hold),
      .load       (tx_load),
      .load_data  (tx_load_data),
      .pop        (tx_fifo_pop),
      .ctrl_taken (ctrl_taken)
   );

   assign stat_throttled   = throttle;
   assign stat_stop_sent   = stop_sent_q;
   assign stat_remote_stop = remote_stop_q;
   assign stat_oob_hold    = oob_hold;

   // R6: a recognised stop character from the far end sets the remote stop state
   p_stop_char_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_inband_en && rx_enable && rx_char_valid && rx_char == cfg_stop_char)
      |=> stat_remote_stop);
   // R8: a disabled receiver leaves the remote stop state alone
   p_rx_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_enable && cfg_inband_en && $stable(cfg_inband_en)) |=> $stable(stat_remote_stop));
   // R3: the sent-stop flag only moves when a control character is loaded
   p_stop_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_load |=> $stable(stat_stop_sent));
   // R2: never both handshake outputs deasserted at once
   p_one_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(rts_n && dtr_n));
endmodule

// File: tb/uart_flow_ctrl_tb_top.sv
module uart_flow_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_inband_en = 1'b0, cfg_oob_en = 1'b0, cfg_oob_pair = 1'b0;
   logic [7:0] cfg_stop_char = 8'h13, cfg_go_char = 8'h11;
   logic [7:0] cfg_thr_hi = 8'd100, cfg_thr_lo = 8'd20;
   logic [7:0] rx_level = 8'd0;
   logic       rx_enable = 1'b1, rx_char_valid = 1'b0;
   logic [7:0] rx_char = 8'h00;
   logic       tx_enable = 1'b1, tx_fifo_valid = 1'b0, tx_shift_idle = 1'b0;
   logic [7:0] tx_fifo_data = 8'hA5;
   logic       cts_n = 1'b0, dsr_n = 1'b0;
   logic       rx_fifo_wr, tx_fifo_pop, tx_load, rts_n, dtr_n;
   logic [7:0] tx_load_data;
   logic       stat_throttled, stat_stop_sent, stat_remote_stop, stat_oob_hold;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   uart_flow_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_inband_en(cfg_inband_en), .cfg_oob_en(cfg_oob_en), .cfg_oob_pair(cfg_oob_pair),
      .cfg_stop_char(cfg_stop_char), .cfg_go_char(cfg_go_char),
      .cfg_thr_hi(cfg_thr_hi), .cfg_thr_lo(cfg_thr_lo), .rx_level(rx_level),
      .rx_enable(rx_enable), .rx_char_valid(rx_char_valid), .rx_char(rx_char),
      .rx_fifo_wr(rx_fifo_wr), .tx_enable(tx_enable), .tx_fifo_valid(tx_fifo_valid),
      .tx_fifo_data(tx_fifo_data), .tx_shift_idle(tx_shift_idle),
      .tx_fifo_pop(tx_fifo_pop), .tx_load(tx_load), .tx_load_data(tx_load_data),
      .cts_n(cts_n), .dsr_n(dsr_n), .rts_n(rts_n), .dtr_n(dtr_n),
      .stat_throttled(stat_throttled), .stat_stop_sent(stat_stop_sent),
      .stat_remote_stop(stat_remote_stop), .stat_oob_hold(stat_oob_hold)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one clock edge, returning at the following falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic settle();
      #2;
   endtask

   task automatic t_reset();
      settle();
      chk("R9 rts_n", rts_n, 0);
      chk("R9 dtr_n", dtr_n, 0);
      chk("R9 tx_load", tx_load, 0);
      chk("R9 tx_fifo_pop", tx_fifo_pop, 0);
      chk("R9 status", {stat_throttled, stat_stop_sent, stat_remote_stop, stat_oob_hold}, 0);
   endtask

   task automatic t_thresholds();
      cfg_oob_en = 1'b1; cfg_oob_pair = 1'b0; cfg_inband_en = 1'b0;
      rx_level = 8'd99; tick(); settle();
      chk("R1 below hi", stat_throttled, 0);
      rx_level = 8'd100; tick(); settle();
      chk("R1 at hi", stat_throttled, 1);
      chk("R2 rts_n throttled", rts_n, 1);
      chk("R2 dtr_n unselected", dtr_n, 0);
      rx_level = 8'd50; tick(); settle();
      chk("R1 hold between", stat_throttled, 1);
      rx_level = 8'd21; tick(); settle();
      chk("R1 just above lo", stat_throttled, 1);
      rx_level = 8'd20; tick(); settle();
      chk("R1 at lo", stat_throttled, 0);
      chk("R2 rts_n released", rts_n, 0);
      cfg_oob_pair = 1'b1; rx_level = 8'd128; tick(); settle();
      chk("R2 dtr_n throttled", dtr_n, 1);
      chk("R2 rts_n unselected", rts_n, 0);
      cfg_oob_en = 1'b0; settle();
      chk("R2 both low when off", {rts_n, dtr_n}, 0);
      rx_level = 8'd0; tick();
      cfg_oob_pair = 1'b0;
   endtask

   task automatic t_inband_send();
      cfg_inband_en = 1'b1; tx_fifo_valid = 1'b1; tx_fifo_data = 8'h5A; tx_shift_idle = 1'b0;
      rx_level = 8'd100; tick(); settle();
      chk("R5 no load while shifter busy", tx_load, 0);
      tx_shift_idle = 1'b1; settle();
      chk("R3 stop load", tx_load, 1);
      chk("R3 stop char", tx_load_data, 8'h13);
      chk("R4 no pop under control", tx_fifo_pop, 0);
      tick(); settle();
      chk("R3 stop sent flag", stat_stop_sent, 1);
      chk("R4 data after control", {tx_load, tx_fifo_pop, tx_load_data}, {2'b11, 8'h5A});
      tx_shift_idle = 1'b0; rx_level = 8'd10; tick();
      tx_enable = 1'b0; tx_shift_idle = 1'b1; settle();
      chk("R5 no load while disabled", tx_load, 0);
      tx_enable = 1'b1; settle();
      chk("R3 go char", {tx_load, tx_fifo_pop, tx_load_data}, {2'b10, 8'h11});
      tick(); settle();
      chk("R3 stop flag cleared", stat_stop_sent, 0);
      chk("R3 only one go", tx_load_data, 8'h5A);
      tx_fifo_valid = 1'b0; tx_shift_idle = 1'b0;
   endtask

   task automatic t_rx_chars();
      cfg_inband_en = 1'b1; tx_fifo_valid = 1'b1; tx_shift_idle = 1'b1;
      rx_char = 8'h13; rx_char_valid = 1'b1; settle();
      chk("R6 stop char consumed", rx_fifo_wr, 0);
      tick(); rx_char_valid = 1'b0; settle();
      chk("R6 remote stop set", stat_remote_stop, 1);
      chk("R6 data blocked", tx_load, 0);
      rx_char = 8'h41; rx_char_valid = 1'b1; settle();
      chk("R6 plain byte written", rx_fifo_wr, 1);
      rx_char = 8'h11; settle();
      chk("R6 go char consumed", rx_fifo_wr, 0);
      tick(); rx_char_valid = 1'b0; settle();
      chk("R6 remote stop cleared", stat_remote_stop, 0);
      chk("R6 data resumes", tx_load, 1);
      cfg_inband_en = 1'b0; rx_char = 8'h13; rx_char_valid = 1'b1; settle();
      chk("R6 stop char written when in-band off", rx_fifo_wr, 1);
      tick(); settle();
      chk("R6 no remote stop when in-band off", stat_remote_stop, 0);
      cfg_inband_en = 1'b1; rx_enable = 1'b0; settle();
      chk("R8 no write while rx off", rx_fifo_wr, 0);
      tick(); rx_char_valid = 1'b0; settle();
      chk("R8 remote stop untouched", stat_remote_stop, 0);
      rx_enable = 1'b1; tx_fifo_valid = 1'b0; tx_shift_idle = 1'b0;
   endtask

   task automatic t_oob_hold();
      cfg_inband_en = 1'b0; cfg_oob_en = 1'b1; cfg_oob_pair = 1'b0;
      tx_fifo_valid = 1'b1; tx_shift_idle = 1'b1;
      cts_n = 1'b1; tick(); settle();
      chk("R7 one edge not yet held", tx_load, 1);
      tick(); settle();
      chk("R7 hold status", stat_oob_hold, 1);
      chk("R7 data halted", tx_load, 0);
      cfg_inband_en = 1'b1; rx_level = 8'd120; tick(); settle();
      chk("R7 control char halted", tx_load, 0);
      cts_n = 1'b0; tick(); tick(); settle();
      chk("R7 control char after release", {tx_load, tx_load_data}, {1'b1, 8'h13});
      cfg_oob_pair = 1'b1; cts_n = 1'b1; dsr_n = 1'b0; tick(); tick(); settle();
      chk("R7 other pair input ignored", stat_oob_hold, 0);
      dsr_n = 1'b1; tick(); tick(); settle();
      chk("R7 dsr hold", {stat_oob_hold, tx_load}, 2'b10);
      dsr_n = 1'b0; cts_n = 1'b0; tx_fifo_valid = 1'b0; tx_shift_idle = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      @(negedge clk); rst_n = 1'b1; @(negedge clk);
      t_reset();
      t_thresholds();
      t_inband_send();
      t_rx_chars();
      t_oob_hold();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule